// File: doc/BRIEF.md
# Sixteen-Bit Five-Function ALU with Gated Logic Unit

This block is the execute stage of a small datapath. Each cycle it may accept two 16-bit operands, a 3-bit operation code and a valid strobe. It produces either a bitwise result (AND, OR, XOR), a 16-bit sum, or a signed 8x8 product. The result appears one clock after the strobe and is flagged by a valid output.

Internally there are three result paths. A ripple-carry adder and a shift-add two's-complement multiplier feed a shared arithmetic result register. The three bitwise functions share one logic unit. That unit's operand register is loaded only when a bitwise operation is issued, so it sits idle while arithmetic runs. A three-state result FSM tracks which path owns the output in the current cycle: `S_IDLE`, `S_LOGIC` or `S_ARITH`. An output multiplexer driven by that state forwards only the matching result.

Each accepted strobe causes one transition. A bitwise code moves the FSM to `S_LOGIC`, ADD or MUL moves it to `S_ARITH`, and no strobe or an undefined code moves it to `S_IDLE`. These transitions can be taken from any state.

Top module: `alu5_core`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, res_valid is 0 and res_data is 0.
- R2: Code 3'b000 (AND) with in_valid high gives res_data = opnd_a & opnd_b in the next cycle.
- R3: Code 3'b001 (OR) with in_valid high gives res_data = opnd_a | opnd_b in the next cycle.
- R4: Code 3'b010 (XOR) with in_valid high gives res_data = opnd_a ^ opnd_b in the next cycle.
- R5: Code 3'b011 (ADD) gives (opnd_a + opnd_b) mod 2^16 in the next cycle. The carry out is dropped.
- R6: Code 3'b100 (MUL) gives the full 16-bit two's-complement product of opnd_a[7:0] and opnd_b[7:0] in the next cycle. Bits [15:8] of both operands have no effect.
- R7: res_valid is 1 exactly in the cycle after a cycle with in_valid high and a code from 3'b000 to 3'b100. A cycle with in_valid low gives res_valid 0 in the next cycle, whatever the other inputs are.
- R8: Codes 3'b101, 3'b110 and 3'b111 with in_valid high give res_valid 0 and res_data 0 in the next cycle.
- R9: res_data is 0 in every cycle in which res_valid is 0.
- R10: The logic unit's operand register loads only when a bitwise operation is accepted and holds otherwise. A bitwise result therefore always reflects its own operands, including after intervening arithmetic operations and on back-to-back bitwise operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op_code | input | 3 | Operation select (000 AND, 001 OR, 010 XOR, 011 ADD, 100 MUL) |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| res_data | output | 16 | Result, zero when not valid |
| res_valid | output | 1 | Result valid, one cycle after the strobe |

## Verification
The assertions assume that the inputs are known and steady at every rising edge while reset is released. They also assume that in_valid is held low during reset, because several properties compare against operand values from the previous cycle. The bench drives every input on the falling edge and keeps in_valid low throughout reset. This gives each property a well-defined previous cycle. Operands are changed even when the strobe is low or the code is undefined, so that properties about holding and ignoring inputs are actually exercised.

// File: rtl/alu5_pkg.sv
package alu5_pkg;
    localparam int DATA_W = 16;
    localparam int MUL_W  = 8;
    localparam int OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_AND = 3'b000,
        OP_OR  = 3'b001,
        OP_XOR = 3'b010,
        OP_ADD = 3'b011,
        OP_MUL = 3'b100
    } op_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'b00,
        S_LOGIC = 2'b01,
        S_ARITH = 2'b10
    } res_state_e;
endpackage

// File: rtl/alu5_ripple_add.sv
module alu5_ripple_add #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] sum
);
    // Carry chain; the final carry is not used by the block.
    logic [WIDTH-1:0] carry;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign sum[i]   = a[i] ^ b[i];
            assign carry[i] = a[i] & b[i];
        end else begin : g_mid
            assign sum[i]   = a[i] ^ b[i] ^ carry[i-1];
            assign carry[i] = (a[i] & b[i]) | (carry[i-1] & (a[i] ^ b[i]));
        end
    end

    logic unused_carry;
    assign unused_carry = carry[WIDTH-1];
endmodule

// File: rtl/alu5_smul.sv
module alu5_smul #(
    parameter int IN_W = 8
) (
    input  logic [IN_W-1:0]   a,
    input  logic [IN_W-1:0]   b,
    output logic [2*IN_W-1:0] prod
);
    localparam int OUT_W = 2 * IN_W;

    // Sign-extend both factors to the product width. The shift-add sum,
    // truncated to OUT_W, then equals the signed product.
    logic [OUT_W-1:0] a_ext;
    logic [OUT_W-1:0] b_ext;
    assign a_ext = {{IN_W{a[IN_W-1]}}, a};
    assign b_ext = {{IN_W{b[IN_W-1]}}, b};

    logic [OUT_W-1:0] acc [OUT_W+1];
    assign acc[0] = '0;

    for (genvar r = 0; r < OUT_W; r++) begin : g_row
        logic [OUT_W-1:0] pp;
        assign pp       = b_ext[r] ? (a_ext << r) : '0;
        assign acc[r+1] = acc[r] + pp;
    end

    assign prod = acc[OUT_W];
endmodule

// File: rtl/alu5_logic_unit.sv
module alu5_logic_unit #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [1:0]       func,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] opa_q,
    output logic [WIDTH-1:0] opb_q,
    output logic [WIDTH-1:0] y
);
    logic [1:0] func_q;

    // Clock-enabled operand register: it loads only on a bitwise issue.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opa_q  <= '0;
            opb_q  <= '0;
            func_q <= '0;
        end else if (load_en) begin
            opa_q  <= a;
            opb_q  <= b;
            func_q <= func;
        end
    end

    always_comb begin
        unique case (func_q)
            2'b00:   y = opa_q & opb_q;
            2'b01:   y = opa_q | opb_q;
            2'b10:   y = opa_q ^ opb_q;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/alu5_core.sv
module alu5_core
    import alu5_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op_code,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] res_data,
    output logic              res_valid
);
    localparam int PROD_W = 2 * MUL_W;

    res_state_e state_q, state_d;

    logic issue_logic, issue_arith;
    logic [DATA_W-1:0] sum_w;
    logic [PROD_W-1:0] prod_w;
    logic [DATA_W-1:0] arith_q;
    logic [DATA_W-1:0] logic_y;
    logic [DATA_W-1:0] lu_opa_q, lu_opb_q;

    assign issue_logic = in_valid && (op_code == OP_AND || op_code == OP_OR || op_code == OP_XOR);
    assign issue_arith = in_valid && (op_code == OP_ADD || op_code == OP_MUL);

    alu5_ripple_add #(.WIDTH(DATA_W)) u_add (
        .a   (opnd_a),
        .b   (opnd_b),
        .sum (sum_w)
    );

    alu5_smul #(.IN_W(MUL_W)) u_mul (
        .a    (opnd_a[MUL_W-1:0]),
        .b    (opnd_b[MUL_W-1:0]),
        .prod (prod_w)
    );

    alu5_logic_unit #(.WIDTH(DATA_W)) u_logic (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (issue_logic),
        .func    (op_code[1:0]),
        .a       (opnd_a),
        .b       (opnd_b),
        .opa_q   (lu_opa_q),
        .opb_q   (lu_opb_q),
        .y       (logic_y)
    );

    // Arithmetic result register, loaded only on an arithmetic issue.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arith_q <= '0;
        end else if (issue_arith) begin
            arith_q <= (op_code == OP_ADD) ? sum_w : DATA_W'(prod_w);
        end
    end

    // Next-state selection.
    always_comb begin
        if (issue_logic)      state_d = S_LOGIC;
        else if (issue_arith) state_d = S_ARITH;
        else                  state_d = S_IDLE;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Output multiplexer, driven by the state.
    always_comb begin
        unique case (state_q)
            S_LOGIC: begin
                res_valid = 1'b1;
                res_data  = logic_y;
            end
            S_ARITH: begin
                res_valid = 1'b1;
                res_data  = arith_q;
            end
            default: begin
                res_valid = 1'b0;
                res_data  = '0;
            end
        endcase
    end
endmodule

// File: rtl/alu5_chk.sv
module alu5_chk
    import alu5_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [OP_W-1:0]   op_code,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic [DATA_W-1:0] res_data,
    input logic              res_valid,
    input logic [DATA_W-1:0] lu_opa_q,
    input logic [DATA_W-1:0] lu_opb_q
);
    logic legal, bitwise;
    logic signed [DATA_W-1:0] ref_prod;
    logic [DATA_W-1:0] ref_sum;

    assign legal    = op_code <= OP_MUL;
    assign bitwise  = op_code <= OP_XOR;
    assign ref_prod = $signed(opnd_a[MUL_W-1:0]) * $signed(opnd_b[MUL_W-1:0]);
    assign ref_sum  = opnd_a + opnd_b;

    always_comb begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (!res_valid && res_data == '0);
        end
    end

    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> res_data == '0);

    p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && legal) |=> res_valid);

    p_no_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid);

    p_bad_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !legal) |=> (!res_valid && res_data == '0));

    p_and_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == OP_AND) |=> res_data == ($past(opnd_a) & $past(opnd_b)));

    p_add_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == OP_ADD) |=> res_data == $past(ref_sum));

    p_mul_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == OP_MUL) |=> res_data == $past(ref_prod));

    p_gate_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && bitwise) |=> ($stable(lu_opa_q) && $stable(lu_opb_q)));
endmodule

bind alu5_core alu5_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_code   (op_code),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .res_data  (res_data),
    .res_valid (res_valid),
    .lu_opa_q  (lu_opa_q),
    .lu_opb_q  (lu_opb_q)
);

// File: tb/tb_alu5_core.sv
module tb_alu5_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op_code = 3'b000;
    logic [15:0] opnd_a = '0;
    logic [15:0] opnd_b = '0;
    logic [15:0] res_data;
    logic        res_valid;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    bit mon_on = 1'b0;

    logic [16:0] q_exp[$];
    string       q_tag[$];

    always #4 clk = ~clk;

    alu5_core dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_code   (op_code),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .res_data  (res_data),
        .res_valid (res_valid)
    );

    function automatic logic [16:0] model(input logic v, input logic [2:0] op,
                                          input logic [15:0] a, input logic [15:0] b);
        logic signed [15:0] p;
        p = $signed(a[7:0]) * $signed(b[7:0]);
        if (!v) return 17'h0;
        case (op)
            3'b000:  return {1'b1, a & b};
            3'b001:  return {1'b1, a | b};
            3'b010:  return {1'b1, a ^ b};
            3'b011:  return {1'b1, 16'(a + b)};
            3'b100:  return {1'b1, p};
            default: return 17'h0;
        endcase
    endfunction

    task automatic step(input logic v, input logic [2:0] op, input logic [15:0] a,
                        input logic [15:0] b, input string tag);
        @(negedge clk);
        in_valid = v;
        op_code  = op;
        opnd_a   = a;
        opnd_b   = b;
        q_exp.push_back(model(v, op, a, b));
        q_tag.push_back(tag);
    endtask

    // Monitor: compares each result 2 ns after the edge that produced it.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (mon_on && q_exp.size() > 0) begin
                logic [16:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                n_run++;
                if ({res_valid, res_data} !== e) begin
                    n_fail++;
                    $display("FAIL %s: got valid=%0b data=%h, expected valid=%0b data=%h",
                             t, res_valid, res_data, e[16], e[15:0]);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        n_run++;
        if (res_valid !== 1'b0 || res_data !== 16'h0) begin
            n_fail++;
            $display("FAIL R1 reset: got valid=%0b data=%h, expected valid=0 data=0000",
                     res_valid, res_data);
        end
        @(negedge clk);
        rst_n  = 1'b1;
        mon_on = 1'b1;

        step(0, 3'b000, 16'h0000, 16'h0000, "R1 first cycle after reset");
        step(1, 3'b000, 16'hE30F, 16'h3CF0, "R2 AND");
        step(1, 3'b000, 16'hFFFF, 16'h0000, "R2 AND zero");
        step(1, 3'b001, 16'h4F0D, 16'h00F0, "R3 OR");
        step(1, 3'b010, 16'hFAFA, 16'hFFFF, "R4 XOR");
        step(1, 3'b011, 16'h1234, 16'h4321, "R5 ADD");
        step(1, 3'b011, 16'hFFFF, 16'h0001, "R5 ADD carry dropped");
        step(1, 3'b011, 16'h8000, 16'h8000, "R5 ADD wrap");
        step(1, 3'b100, 16'h0007, 16'h0006, "R6 MUL positive");
        step(1, 3'b100, 16'hAAFF, 16'h5502, "R6 MUL -1*2, upper bytes ignored");
        step(1, 3'b100, 16'h0080, 16'h0080, "R6 MUL -128*-128");
        step(1, 3'b100, 16'h007F, 16'h0080, "R6 MUL 127*-128");
        step(0, 3'b000, 16'hFFFF, 16'hFFFF, "R7 no strobe");
        step(0, 3'b011, 16'h1111, 16'h2222, "R7 no strobe with ADD code");
        step(1, 3'b101, 16'hFFFF, 16'hFFFF, "R8 code 101");
        step(1, 3'b110, 16'h1234, 16'h5678, "R8 code 110");
        step(1, 3'b111, 16'hAAAA, 16'h5555, "R8 code 111 / R9 zero");
        step(1, 3'b000, 16'h0F0F, 16'h00FF, "R10 AND before arithmetic");
        step(1, 3'b011, 16'hDEAD, 16'hBEEF, "R10 ADD between");
        step(1, 3'b100, 16'h00FE, 16'h0003, "R10 MUL between");
        step(1, 3'b001, 16'hA000, 16'h000B, "R10 OR after arithmetic");
        step(1, 3'b010, 16'h1357, 16'h2468, "R10 back-to-back XOR");
        step(1, 3'b000, 16'hC3C3, 16'h0FF0, "R10 back-to-back AND");
        step(0, 3'b010, 16'h9999, 16'h6666, "R9 idle after logic");
        step(1, 3'b010, 16'h0000, 16'h0000, "R10 XOR after idle");
        step(0, 3'b000, 16'h0000, 16'h0000, "R7 drain");
        step(0, 3'b000, 16'h0000, 16'h0000, "R7 drain");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule